// File: doc/BRIEF.md
# Maskable Eight-Line Interrupt Latch

This block collects interrupt requests from eight device lines into a pending register and drives a single level-sensitive request to an upstream interrupt controller. Devices raise or drop lines by presenting bit vectors on a post input and a clear input. Software reaches the block over a byte-wide register bus that has separate write and read strobes and a size code. Through it, software programs an enable mask, acknowledges one line at a time by its index, and reads back the pending lines.

The mask port stores the complement of the written byte, so writing a 0 in a bit position enables that line. A second controller slot is decoded so that software written for a cascaded pair of controllers runs without faults. That slot reads as zero, keeps whatever is written to its mask, and never requests an interrupt. An access the block does not decode raises a one-cycle error flag and has no effect. This includes an unknown offset, a size the port does not take, a read of a write-only port, a write of a read-only port, and both strobes together.

Register offsets: 0 primary status (read), 1 primary mask (write), 2 primary acknowledge (write), 4 secondary status (read), 5 secondary mask (write), 6 secondary acknowledge (write). Size codes: 0 byte, 1 half, 2 word, 3 double word (64-bit).

Top module: `irq_latch_top`

## Requirements
- R1: After reset, pending is 0x00, every line is masked, `irq_out` and `reg_err` are low, and `reg_rdata` is zero.
- R2: A byte write to offset 1 loads the enable register with the complement of `reg_wdata`. A line whose written bit is 0 is enabled, and a line whose written bit is 1 is masked.
- R3: `irq_out` is high exactly when some pending bit is also enabled. It follows every mask write, post, clear and acknowledge at the same clock edge that updates the state.
- R4: A byte write to offset 2 clears the pending bit whose index is `reg_wdata[3:0]`. Indices 8 to 15 clear nothing.
- R5: `dev_post` ORs its vector into pending and `dev_clear` removes its vector from pending. When both name the same bit in one cycle, the clear is applied after the post and the bit ends clear.
- R6: When a post and an acknowledge hit the same bit in one cycle, that bit ends clear. Other bits posted in the same cycle stay pending.
- R7: A read of offset 0 with size 0 (byte) or size 3 (64-bit) returns pending in `reg_rdata[7:0]` with all upper bits zero. The data appears after the clock edge that samples the read strobe.
- R8: A byte read of offset 4 returns zero. Byte writes to offsets 5 and 6 raise no error and change neither pending nor `irq_out`.
- R9: Each of the following pulses `reg_err` high for the one cycle after the access: an undecoded offset, a write with a size other than byte, a 64-bit read of offset 4, a read of a write-only offset, a write to a read-only offset, or both strobes in one cycle. The access changes no state, and a faulting read returns zero data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_size | input | 2 | Access size code (0 byte, 3 double word) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 64 | Read data, valid after the edge that samples the read |
| reg_err | output | 1 | One-cycle flag for a faulting access |
| dev_post | input | 8 | Lines to set pending this cycle |
| dev_clear | input | 8 | Lines to clear pending this cycle |
| irq_out | output | 1 | Level interrupt request to the upstream controller |

## Verification
Every result is registered exactly once. Pending, enable and `irq_out` change at the edge that samples a post, clear or register write. `reg_rdata` and `reg_err` change at the edge that samples the access. So every result is due one edge after its stimulus. The bench drives inputs at a falling edge and removes them at the next falling edge. It checks the outputs at that second falling edge, which is half a cycle after the edge that made them. For the error flag, it also looks one cycle later to confirm that the pulse has ended. Pending values are read back through the status port, and each reaches `reg_rdata` one edge after its read.

// File: rtl/irql_pkg.sv
// Shared definitions for the interrupt latch: register offsets, access
// size codes and the decoded operation type.
// Assumes: offsets fit in the address width chosen by the top.
package irql_pkg;
    localparam int OFS_PRI_STAT = 0;
    localparam int OFS_PRI_MASK = 1;
    localparam int OFS_PRI_ACK  = 2;
    localparam int OFS_SEC_STAT = 4;
    localparam int OFS_SEC_MASK = 5;
    localparam int OFS_SEC_ACK  = 6;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PRI_RD,
        OP_PRI_MASK,
        OP_PRI_ACK,
        OP_SEC_RD,
        OP_SEC_MASK,
        OP_SEC_ACK,
        OP_BAD
    } reg_op_e;
endpackage

// File: rtl/irql_decode.sv
// Register access decoder: turns strobes, offset and size into one
// operation code. Any access that is not supported maps to OP_BAD.
// Assumes: at most one access per cycle; purely combinational.
module irql_decode
    import irql_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output reg_op_e           op
);
    localparam logic [ADDR_W-1:0] A_PRI_STAT = ADDR_W'(OFS_PRI_STAT);
    localparam logic [ADDR_W-1:0] A_PRI_MASK = ADDR_W'(OFS_PRI_MASK);
    localparam logic [ADDR_W-1:0] A_PRI_ACK  = ADDR_W'(OFS_PRI_ACK);
    localparam logic [ADDR_W-1:0] A_SEC_STAT = ADDR_W'(OFS_SEC_STAT);
    localparam logic [ADDR_W-1:0] A_SEC_MASK = ADDR_W'(OFS_SEC_MASK);
    localparam logic [ADDR_W-1:0] A_SEC_ACK  = ADDR_W'(OFS_SEC_ACK);

    logic is_byte;
    logic is_dword;
    assign is_byte  = (size == SZ_BYTE);
    assign is_dword = (size == SZ_DWORD);

    // Classify the current access.
    always_comb begin
        op = OP_NONE;
        if (wr && rd) begin
            op = OP_BAD;
        end else if (rd) begin
            if (addr == A_PRI_STAT)
                op = (is_byte || is_dword) ? OP_PRI_RD : OP_BAD;
            else if (addr == A_SEC_STAT)
                op = is_byte ? OP_SEC_RD : OP_BAD;
            else
                op = OP_BAD;
        end else if (wr) begin
            if (!is_byte)                op = OP_BAD;
            else if (addr == A_PRI_MASK) op = OP_PRI_MASK;
            else if (addr == A_PRI_ACK)  op = OP_PRI_ACK;
            else if (addr == A_SEC_MASK) op = OP_SEC_MASK;
            else if (addr == A_SEC_ACK)  op = OP_SEC_ACK;
            else                         op = OP_BAD;
        end
    end
endmodule

// File: rtl/irql_core.sv
// Pending latch, enable register and interrupt level. Each cycle the
// post vector is applied first, then the clear vector and acknowledge,
// and the output level is recomputed from the new state at that edge.
// Assumes: ack_idx values at or above NLINES name no line.
module irql_core #(
    parameter int NLINES = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [NLINES-1:0] enable_in,
    input  logic              ack_we,
    input  logic [IDX_W-1:0]  ack_idx,
    input  logic [NLINES-1:0] set_i,
    input  logic [NLINES-1:0] clr_i,
    output logic [NLINES-1:0] pending_o,
    output logic [NLINES-1:0] enable_o,
    output logic              irq_o
);
    logic [NLINES-1:0] pending_q, enable_q, ack_vec, pend_next, en_next;
    logic              irq_q;

    // Decode the acknowledge index into a one-hot clear vector.
    always_comb begin
        ack_vec = '0;
        for (int i = 0; i < NLINES; i++)
            ack_vec[i] = ack_we && (ack_idx == IDX_W'(i));
    end

    // Next state: post, then clear and acknowledge; mask on write.
    always_comb begin
        pend_next = ((pending_q | set_i) & ~clr_i) & ~ack_vec;
        en_next   = mask_we ? enable_in : enable_q;
    end

    // State registers and output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            enable_q  <= '0;
            irq_q     <= 1'b0;
        end else begin
            pending_q <= pend_next;
            enable_q  <= en_next;
            irq_q     <= |(pend_next & en_next);
        end
    end

    assign pending_o = pending_q;
    assign enable_o  = enable_q;
    assign irq_o     = irq_q;

    assert_irq_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == |(pending_q & enable_q));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> ((pending_q & $past(ack_vec)) == '0));

    assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_vec));

    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((pending_q & $past(clr_i)) == '0));

    assert_post_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pending_q & $past(set_i & ~clr_i & ~ack_vec))
                      == $past(set_i & ~clr_i & ~ack_vec)));
endmodule

// File: rtl/irql_resp.sv
// Response stage: registers read data and the error flag. Any read
// strobe loads the data register; only a good primary status read
// loads pending (zero-extended), everything else loads zero.
// Assumes: pending is sampled in the same cycle as the read strobe.
module irql_resp #(
    parameter int NLINES = 8,
    parameter int RD_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              rd_pri,
    input  logic              bad,
    input  logic [NLINES-1:0] pending,
    output logic [RD_W-1:0]   rdata,
    output logic              err
);
    logic [RD_W-1:0] rdata_q;
    logic            err_q;

    // Capture read data and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (rd_strobe)
                rdata_q <= rd_pri ? RD_W'(pending) : '0;
            err_q <= bad;
        end
    end

    assign rdata = rdata_q;
    assign err   = err_q;

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_q[RD_W-1:NLINES] == '0);
endmodule

// File: rtl/irq_latch_top.sv
// Maskable interrupt latch top: register decode, pending/enable core,
// response stage and the inert secondary mask register.
// Assumes: DATA_W lines, at least 4 bits wide so an index fits.
module irq_latch_top
    import irql_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int RD_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [RD_W-1:0]   reg_rdata,
    output logic              reg_err,
    input  logic [DATA_W-1:0] dev_post,
    input  logic [DATA_W-1:0] dev_clear,
    output logic              irq_out
);
    localparam int IDX_W = 4;

    reg_op_e           op;
    logic [DATA_W-1:0] pending, enable, sec_mask_q;
    logic              sec_mask_unused;

    irql_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .size(reg_size), .op(op)
    );

    irql_core #(.NLINES(DATA_W), .IDX_W(IDX_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .mask_we(op == OP_PRI_MASK), .enable_in(~reg_wdata),
        .ack_we(op == OP_PRI_ACK), .ack_idx(reg_wdata[IDX_W-1:0]),
        .set_i(dev_post), .clr_i(dev_clear),
        .pending_o(pending), .enable_o(enable), .irq_o(irq_out)
    );

    irql_resp #(.NLINES(DATA_W), .RD_W(RD_W)) u_resp (
        .clk(clk), .rst_n(rst_n),
        .rd_strobe(reg_rd), .rd_pri(op == OP_PRI_RD), .bad(op == OP_BAD),
        .pending(pending), .rdata(reg_rdata), .err(reg_err)
    );

    // Secondary mask: stored for software, drives nothing.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sec_mask_q <= '0;
        else if (op == OP_SEC_MASK) sec_mask_q <= reg_wdata;
    end
    assign sec_mask_unused = ^sec_mask_q;

    assert_mask_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PRI_MASK) |=> (enable == ~$past(reg_wdata)));

    assert_sec_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SEC_RD) |=> (reg_rdata == '0));

    assert_sec_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SEC_ACK || op == OP_SEC_MASK) |=> $stable(enable));

    assert_err_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $stable(enable));
endmodule

// File: tb/irq_latch_top_tb.sv
`timescale 1ns/100ps
module irq_latch_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [7:0]  reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err;
    logic [7:0]  dev_post = '0, dev_clear = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_pend = '0;
    logic [7:0] exp_en = '0;

    always #2.5 clk = ~clk;

    irq_latch_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .dev_post(dev_post),
        .dev_clear(dev_clear), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One register access; returns at the falling edge after the sampling edge.
    task automatic access(input logic w, input logic r, input logic [3:0] a,
                          input logic [1:0] sz, input logic [7:0] d);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    endtask

    task automatic device(input logic [7:0] p, input logic [7:0] c);
        dev_post = p; dev_clear = c;
        @(negedge clk);
        dev_post = '0; dev_clear = '0;
        exp_pend = (exp_pend | p) & ~c;
    endtask

    task automatic check_pending(input string req);
        access(1'b0, 1'b1, 4'd0, 2'd0, 8'h00);
        chk(reg_rdata == {56'h0, exp_pend}, req, reg_rdata, {56'h0, exp_pend});
        chk(irq_out == |(exp_pend & exp_en), {req, " irq"}, 64'(irq_out),
            64'(|(exp_pend & exp_en)));
    endtask

    task automatic t_reset();
        chk(irq_out == 1'b0, "R1 irq", 64'(irq_out), 0);
        chk(reg_err == 1'b0, "R1 err", 64'(reg_err), 0);
        chk(reg_rdata == 64'h0, "R1 rdata", reg_rdata, 0);
        check_pending("R1 pending");
        device(8'hFF, 8'h00);
        chk(irq_out == 1'b0, "R1 all masked", 64'(irq_out), 0);
        device(8'h00, 8'hFF);
    endtask

    task automatic t_mask();
        access(1'b1, 1'b0, 4'd1, 2'd0, 8'hFE); exp_en = 8'h01;
        device(8'h02, 8'h00);
        chk(irq_out == 1'b0, "R2 masked line quiet", 64'(irq_out), 0);
        device(8'h01, 8'h00);
        chk(irq_out == 1'b1, "R3 enabled line raises", 64'(irq_out), 1);
        access(1'b1, 1'b0, 4'd1, 2'd0, 8'hFF); exp_en = 8'h00;
        chk(irq_out == 1'b0, "R2 mask all drops irq", 64'(irq_out), 0);
        access(1'b1, 1'b0, 4'd1, 2'd0, 8'hFD); exp_en = 8'h02;
        chk(irq_out == 1'b1, "R3 unmask pending raises", 64'(irq_out), 1);
        access(1'b1, 1'b0, 4'd1, 2'd0, 8'hFE); exp_en = 8'h01;
    endtask

    task automatic t_read();
        check_pending("R7 byte read");
        access(1'b0, 1'b1, 4'd0, 2'd3, 8'h00);
        chk(reg_rdata == {56'h0, exp_pend} && !reg_err, "R7 dword read",
            reg_rdata, {56'h0, exp_pend});
    endtask

    task automatic t_ack();
        access(1'b1, 1'b0, 4'd2, 2'd0, 8'hF0); exp_pend[0] = 1'b0;
        chk(irq_out == 1'b0, "R4 ack drops irq", 64'(irq_out), 0);
        check_pending("R4 ack index 0");
        access(1'b1, 1'b0, 4'd2, 2'd0, 8'h19);
        check_pending("R4 ack index 9 no effect");
        access(1'b1, 1'b0, 4'd2, 2'd0, 8'h01); exp_pend[1] = 1'b0;
        check_pending("R4 ack index 1");
    endtask

    task automatic t_clear();
        device(8'h0C, 8'h04);
        check_pending("R5 post and clear same bit");
        device(8'h00, 8'h08);
        check_pending("R5 clear vector");
    endtask

    task automatic t_ack_post();
        dev_post = 8'h30;
        access(1'b1, 1'b0, 4'd2, 2'd0, 8'h04);
        dev_post = '0;
        exp_pend = 8'h20;
        check_pending("R6 ack beats post on same bit");
    endtask

    task automatic t_secondary();
        device(8'h01, 8'h00);
        access(1'b0, 1'b1, 4'd4, 2'd0, 8'h00);
        chk(reg_rdata == 64'h0 && !reg_err, "R8 secondary read", reg_rdata, 0);
        access(1'b1, 1'b0, 4'd5, 2'd0, 8'h00);
        chk(reg_err == 1'b0, "R8 secondary mask no error", 64'(reg_err), 0);
        access(1'b1, 1'b0, 4'd6, 2'd0, 8'h00);
        chk(reg_err == 1'b0, "R8 secondary ack no error", 64'(reg_err), 0);
        check_pending("R8 secondary writes inert");
        device(8'h80, 8'h00);
        chk(irq_out == 1'b1, "R8 irq unchanged by secondary", 64'(irq_out), 1);
    endtask

    task automatic bad(input logic w, input logic r, input logic [3:0] a,
                       input logic [1:0] sz, input logic [7:0] d, input string req);
        access(w, r, a, sz, d);
        chk(reg_err == 1'b1, req, 64'(reg_err), 1);
        if (r) chk(reg_rdata == 64'h0, {req, " data"}, reg_rdata, 0);
        @(negedge clk);
        chk(reg_err == 1'b0, {req, " pulse ends"}, 64'(reg_err), 0);
    endtask

    task automatic t_errors();
        bad(1'b1, 1'b0, 4'd3, 2'd0, 8'hFF, "R9 undecoded offset");
        bad(1'b1, 1'b0, 4'd1, 2'd1, 8'hFF, "R9 half-size mask write");
        bad(1'b1, 1'b0, 4'd2, 2'd3, 8'h00, "R9 dword ack write");
        bad(1'b0, 1'b1, 4'd1, 2'd0, 8'h00, "R9 read of mask");
        bad(1'b0, 1'b1, 4'd4, 2'd3, 8'h00, "R9 dword secondary read");
        bad(1'b1, 1'b0, 4'd0, 2'd0, 8'h00, "R9 write to status");
        bad(1'b1, 1'b1, 4'd2, 2'd0, 8'h00, "R9 both strobes");
        check_pending("R9 state unchanged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_read();
        t_ack();
        t_clear();
        t_ack_post();
        t_secondary();
        t_errors();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule